// File: doc/BRIEF.md
# EEPROM Page Write Controller

This block sits between a parallel memory bus and a small byte-wide nonvolatile array. It watches the bus select and strobe pins on every clock. A write strobe loads the captured address and data into a page buffer. Further strobes that land in the same page join the buffer, provided each one starts soon enough after the previous one ends. When no strobe arrives within that window, the block commits the whole buffered page in one self-timed internal write cycle.

During the internal cycle the ready/busy pin is driven low. A read returns a status byte instead of array data. That status byte carries a data-polling bit and a toggle bit. A host can therefore detect completion either by watching the pin or by polling the bus. The array itself is a plain register file that stands in for the real cells. The bus pins are treated as synchronous to `clk`.

Top module: `eepromPageWriter`

## Requirements
- R1: After reset `rdyBusyN` is 1 and every array byte reads as 8'hFF.
- R2: A write strobe exists only while `eepromSelN`=0, `flashSelN`=1, `oeN`=1 and `weN`=0. A low on `weN` with `flashSelN`=0 or with `oeN`=0 writes nothing and starts no internal cycle.
- R3: The address is taken in the first cycle in which both `eepromSelN` and `weN` are sampled low, whichever of them fell later. The data byte is the last value of `dataIn` sampled before the strobe ends.
- R4: The page is `addr[ADDR_W-1:log2(PAGE_BYTES)]` of the first byte. The low bits select the byte within the page. Strobes to any other page are ignored. Up to PAGE_BYTES bytes are committed together, and a repeated offset keeps the newest byte.
- R5: A strobe joins the open page when it is first sampled no more than WINDOW_CYC cycles after the cycle in which the previous accepted strobe was seen ending. Otherwise the internal cycle begins exactly WINDOW_CYC cycles after that end, and `rdyBusyN` is first seen low WINDOW_CYC+1 cycles after the releasing edge.
- R6: The internal cycle lasts exactly WRITE_CYC clock cycles, and `rdyBusyN` is 0 for all of them.
- R7: Write strobes that begin while busy are ignored. They change no byte and start no further cycle.
- R8: A read (`eepromSelN`=0, `flashSelN`=1, `oeN`=0, `weN`=1) while busy returns a status byte. Bit 7 is the inverse of bit 7 of the last accepted byte. Bit 6 is 0 when the cycle starts and inverts at each read strobe start. Bits 5:0 are 0.
- R9: When not busy, `dataOut` shows the array byte at `addr`. After a cycle, every committed byte reads back its new value and every other byte is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| eepromSelN | input | 1 | EEPROM block select, active low |
| flashSelN | input | 1 | Companion flash block select, active low; must be high for EEPROM access |
| weN | input | 1 | Write enable, active low |
| oeN | input | 1 | Output enable, active low |
| addr | input | ADDR_W | Byte address |
| dataIn | input | 8 | Write data |
| dataOut | output | 8 | Array data, or the status byte while busy |
| rdyBusyN | output | 1 | 0 during the internal write cycle |

## Verification
The bench probes the window edge from both sides. A strobe started exactly WINDOW_CYC cycles after the previous one must still join the page. One started a cycle later must be dropped, because the cycle has already begun. An off-by-one counter would either split the page or swallow the late byte.

It staggers the select and write-enable falls while moving the address, to catch a design that latches on the first fall. It changes the data during a strobe, to catch one that latches data at the wrong moment. It also sends off-page strobes and strobes during busy: a leaky design would corrupt another page or chain a second cycle.

The status reads check polling polarity for both values of bit 7, and check that the toggle bit alternates between reads. A full sweep of every page then confirms exact busy length and readback.

// File: rtl/ewPkg.sv
package ewPkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_LOAD = 2'd1,
    ST_BUSY = 2'd2
  } ewState_t;

  // control-to-datapath strobes, one cycle each except holdData
  typedef struct packed {
    logic newPage;     // open a page with the address on the bus
    logic capAddr;     // take the byte offset from the bus
    logic holdData;    // track dataIn while the strobe is live
    logic storeByte;   // strobe ended: put held byte in the page buffer
    logic startWrite;  // window lapsed: internal cycle begins
    logic finishWrite; // last busy cycle: copy buffer into the array
    logic readPulse;   // a read strobe just began
  } ewStrobe_t;

endpackage

// File: rtl/ewControl.sv
module ewControl
  import ewPkg::*;
#(
  parameter int WINDOW_CYC = 6,
  parameter int WRITE_CYC  = 20
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      eepromSelN,
  input  logic      flashSelN,
  input  logic      weN,
  input  logic      oeN,
  input  logic      pageHit,
  output ewStrobe_t strb,
  output logic      busy
);

  localparam int WIN_W  = $clog2(WINDOW_CYC + 1);
  localparam int BUSY_W = $clog2(WRITE_CYC + 1);

  ewState_t          state;
  logic              wrQ, rdQ, armed;
  logic [WIN_W-1:0]  winCnt;
  logic [BUSY_W-1:0] busyCnt;

  logic wrAct, rdAct, wrRise, wrFall, rdRise, acceptRise;

  assign wrAct  = !eepromSelN && flashSelN && !weN && oeN;
  assign rdAct  = !eepromSelN && flashSelN && !oeN && weN;
  assign wrRise = wrAct && !wrQ;
  assign wrFall = !wrAct && wrQ;
  assign rdRise = rdAct && !rdQ;

  assign acceptRise = wrRise &&
                      ((state == ST_IDLE) || ((state == ST_LOAD) && pageHit));

  always_comb begin
    strb             = '0;
    strb.newPage     = wrRise && (state == ST_IDLE);
    strb.capAddr     = acceptRise;
    strb.holdData    = acceptRise || (armed && wrAct);
    strb.storeByte   = wrFall && armed;
    strb.startWrite  = (state == ST_LOAD) && !armed && !acceptRise &&
                       (winCnt == WIN_W'(WINDOW_CYC - 1));
    strb.finishWrite = (state == ST_BUSY) && (busyCnt == BUSY_W'(WRITE_CYC - 1));
    strb.readPulse   = rdRise;
  end

  assign busy = (state == ST_BUSY);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      wrQ     <= 1'b0;
      rdQ     <= 1'b0;
      armed   <= 1'b0;
      winCnt  <= '0;
      busyCnt <= '0;
    end else begin
      wrQ <= wrAct;
      rdQ <= rdAct;

      if (acceptRise)  armed <= 1'b1;
      else if (wrFall) armed <= 1'b0;

      if (armed || acceptRise)    winCnt <= '0;
      else if (state == ST_LOAD)  winCnt <= winCnt + 1'b1;

      if (strb.startWrite)        busyCnt <= '0;
      else if (state == ST_BUSY)  busyCnt <= busyCnt + 1'b1;

      unique case (state)
        ST_IDLE: if (acceptRise)       state <= ST_LOAD;
        ST_LOAD: if (strb.startWrite)  state <= ST_BUSY;
        ST_BUSY: if (strb.finishWrite) state <= ST_IDLE;
        default:                       state <= ST_IDLE;
      endcase
    end
  end

  AST_ARMED_ONLY_LOAD: assert property (@(posedge clk) disable iff (!rstN)
    armed |-> (state == ST_LOAD)); // R7

  AST_WINDOW_BOUND: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_LOAD && !armed) |-> (winCnt < WIN_W'(WINDOW_CYC))); // R5

  AST_BUSY_FROM_LOAD: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> $past(state == ST_LOAD)); // R5

endmodule

// File: rtl/ewDatapath.sv
module ewDatapath
  import ewPkg::*;
#(
  parameter int ADDR_W     = 10,
  parameter int PAGE_BYTES = 64
) (
  input  logic              clk,
  input  logic              rstN,
  input  ewStrobe_t         strb,
  input  logic              busy,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        dataIn,
  output logic              pageHit,
  output logic [7:0]        dataOut
);

  localparam int OFF_W  = $clog2(PAGE_BYTES);
  localparam int TAG_W  = ADDR_W - OFF_W;
  localparam int DEPTH  = 1 << ADDR_W;

  logic [TAG_W-1:0]      pageTag;
  logic [OFF_W-1:0]      curOff;
  logic [7:0]            heldByte;
  logic [7:0]            pageBuf  [PAGE_BYTES];
  logic [PAGE_BYTES-1:0] validMask;
  logic                  lastBit7;
  logic                  toggleBit;
  logic [7:0]            memArr   [DEPTH];

  assign pageHit = (addr[ADDR_W-1:OFF_W] == pageTag);
  assign dataOut = busy ? {~lastBit7, toggleBit, 6'b0} : memArr[addr];

  // page buffer, tag and status bits
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pageTag   <= '0;
      curOff    <= '0;
      heldByte  <= '0;
      validMask <= '0;
      lastBit7  <= 1'b0;
      toggleBit <= 1'b0;
      for (int i = 0; i < PAGE_BYTES; i++) pageBuf[i] <= '0;
    end else begin
      if (strb.newPage)  pageTag  <= addr[ADDR_W-1:OFF_W];
      if (strb.capAddr)  curOff   <= addr[OFF_W-1:0];
      if (strb.holdData) heldByte <= dataIn;
      if (strb.storeByte) begin
        pageBuf[curOff]   <= heldByte;
        validMask[curOff] <= 1'b1;
        lastBit7          <= heldByte[7];
      end
      if (strb.startWrite)              toggleBit <= 1'b0;
      else if (strb.readPulse && busy)  toggleBit <= ~toggleBit;
      if (strb.finishWrite) validMask <= '0;
    end
  end

  // stand-in cell array, erased value 8'hFF
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int j = 0; j < DEPTH; j++) memArr[j] <= 8'hFF;
    end else if (strb.finishWrite) begin
      for (int i = 0; i < PAGE_BYTES; i++) begin
        if (validMask[i]) memArr[{pageTag, OFF_W'(i)}] <= pageBuf[i];
      end
    end
  end

  AST_START_HAS_DATA: assert property (@(posedge clk) disable iff (!rstN)
    strb.startWrite |-> (validMask != '0)); // R4

  AST_NO_STORE_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    strb.storeByte |-> !busy); // R7

  AST_TAG_HELD_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    (busy && $past(busy)) |-> $stable(pageTag)); // R7

endmodule

// File: rtl/eepromPageWriter.sv
module eepromPageWriter
  import ewPkg::*;
#(
  parameter int ADDR_W     = 10,
  parameter int PAGE_BYTES = 64,
  parameter int WINDOW_CYC = 6,
  parameter int WRITE_CYC  = 20
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              eepromSelN,
  input  logic              flashSelN,
  input  logic              weN,
  input  logic              oeN,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        dataIn,
  output logic [7:0]        dataOut,
  output logic              rdyBusyN
);

  localparam int RUN_W = $clog2(WRITE_CYC + 2);

  ewStrobe_t strb;
  logic      busy, pageHit;

  ewControl #(.WINDOW_CYC(WINDOW_CYC), .WRITE_CYC(WRITE_CYC)) uCtrl (
    .clk(clk), .rstN(rstN), .eepromSelN(eepromSelN), .flashSelN(flashSelN),
    .weN(weN), .oeN(oeN), .pageHit(pageHit), .strb(strb), .busy(busy)
  );

  ewDatapath #(.ADDR_W(ADDR_W), .PAGE_BYTES(PAGE_BYTES)) uPath (
    .clk(clk), .rstN(rstN), .strb(strb), .busy(busy), .addr(addr),
    .dataIn(dataIn), .pageHit(pageHit), .dataOut(dataOut)
  );

  assign rdyBusyN = !busy;

  // busy-run length, kept only for the check below
  logic [RUN_W-1:0] runLen;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                                  runLen <= '0;
    else if (!rdyBusyN && runLen != '1)         runLen <= runLen + 1'b1;
    else if (rdyBusyN)                          runLen <= '0;
  end

  AST_BUSY_LEN: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rdyBusyN) |-> ($past(runLen) == RUN_W'(WRITE_CYC - 1))); // R6

  AST_STATUS_LOW_BITS: assert property (@(posedge clk) disable iff (!rstN)
    !rdyBusyN |-> (dataOut[5:0] == 6'd0)); // R8

endmodule

// File: tb/tb_eepromPageWriter.sv
module tb_eepromPageWriter;

  localparam int CLK_PERIOD = 10;
  localparam int AW   = 6;
  localparam int PB   = 8;
  localparam int W    = 6;
  localparam int WC   = 20;
  localparam int NPG  = (1 << AW) / PB;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          eepromSelN = 1'b1, flashSelN = 1'b1, weN = 1'b1, oeN = 1'b1;
  logic [AW-1:0] addr = '0;
  logic [7:0]    dataIn = '0;
  logic [7:0]    dataOut;
  logic          rdyBusyN;

  int nChk = 0, nFail = 0;
  int model [1 << AW];

  always #(CLK_PERIOD / 2) clk = ~clk;

  eepromPageWriter #(.ADDR_W(AW), .PAGE_BYTES(PB), .WINDOW_CYC(W), .WRITE_CYC(WC)) dut (
    .clk(clk), .rstN(rstN), .eepromSelN(eepromSelN), .flashSelN(flashSelN),
    .weN(weN), .oeN(oeN), .addr(addr), .dataIn(dataIn), .dataOut(dataOut),
    .rdyBusyN(rdyBusyN)
  );

  task automatic check(input string req, input int got, input int exp);
    nChk++;
    if (got !== exp) begin
      nFail++;
      $display("FAIL %s: got %0h expected %0h", req, got, exp);
    end
  endtask

  // called at a negedge, returns at the releasing negedge
  task automatic strobe(input int a, input int d);
    addr = AW'(a); dataIn = 8'(d); eepromSelN = 1'b0; weN = 1'b0;
    repeat (2) @(negedge clk);
    eepromSelN = 1'b1; weN = 1'b1;
  endtask

  task automatic gap(input int g);
    repeat (g) @(negedge clk);
  endtask

  task automatic readByte(input int a, output int v);
    addr = AW'(a); eepromSelN = 1'b0; oeN = 1'b0;
    @(negedge clk);
    v = int'(dataOut);
    eepromSelN = 1'b1; oeN = 1'b1;
    @(negedge clk);
  endtask

  // from the releasing negedge: wait through one internal cycle
  task automatic awaitCycle(input bit chk);
    int toBusy = 0, lows = 0;
    while (rdyBusyN && toBusy < 1000) begin @(negedge clk); toBusy++; end
    while (!rdyBusyN && lows < 1000) begin lows++; @(negedge clk); end
    if (chk) begin
      check("R5 busy start", toBusy, W + 1);
      check("R6 busy length", lows, WC);
    end
  endtask

  task automatic waitReady();
    int n = 0;
    while (!rdyBusyN && n < 1000) begin @(negedge clk); n++; end
  endtask

  task automatic checkAll(input string req);
    int v;
    for (int a = 0; a < (1 << AW); a++) begin
      readByte(a, v);
      check(req, v, model[a]);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    nFail++;
    $display("FAIL watchdog expired, R6 cycle never ended");
    $display("  == %0d vectors applied, %0d miscompares ==", nChk, nFail);
    $finish;
  end

  initial begin
    int v, v2;
    for (int a = 0; a < (1 << AW); a++) model[a] = 8'hFF;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1: reset state
    check("R1 ready after reset", int'(rdyBusyN), 1);
    checkAll("R1 erased readback");

    // R2: flash select low, then output enable low: nothing written
    flashSelN = 1'b0; strobe(5, 8'h12); flashSelN = 1'b1;
    gap(W + 3);
    check("R2 no cycle flashSel low", int'(rdyBusyN), 1);
    oeN = 1'b0; strobe(6, 8'h34); oeN = 1'b1;
    gap(W + 3);
    check("R2 no cycle oeN low", int'(rdyBusyN), 1);
    readByte(5, v); check("R2 byte 5 untouched", v, 8'hFF);
    readByte(6, v); check("R2 byte 6 untouched", v, 8'hFF);

    // R3: select falls first, write enable later with new address
    addr = 6'd9; dataIn = 8'h11; eepromSelN = 1'b0;
    gap(2);
    addr = 6'd10; weN = 1'b0;
    gap(1); dataIn = 8'h5A; gap(1); dataIn = 8'h6B; gap(1);
    eepromSelN = 1'b1; weN = 1'b1;
    model[10] = 8'h6B;
    awaitCycle(1'b1);
    readByte(9, v);  check("R3 early address ignored", v, 8'hFF);
    readByte(10, v); check("R3 later-fall address, last data", v, 8'h6B);
    // write enable falls first
    addr = 6'd17; dataIn = 8'h22; weN = 1'b0;
    gap(2);
    addr = 6'd18; dataIn = 8'h77; eepromSelN = 1'b0;
    gap(2);
    eepromSelN = 1'b1; weN = 1'b1;
    model[18] = 8'h77;
    awaitCycle(1'b1);
    readByte(17, v); check("R3 early address ignored (we first)", v, 8'hFF);
    readByte(18, v); check("R3 select-fall address", v, 8'h77);

    // R4 R5 R6 R9: full-page sweep of every page, gaps inside the window
    for (int p = 0; p < NPG; p++) begin
      for (int o = 0; o < PB; o++) begin
        int a = p * PB + o;
        int d = (a * 29 + 7) & 255;
        strobe(a, d);
        model[a] = d;
        if (o != PB - 1) gap((o % W) + 1);
      end
      awaitCycle(1'b1);
    end
    checkAll("R9 sweep readback");

    // R4: partial page, repeated offset keeps newest
    strobe(25, 8'hA1); gap(2);
    strobe(28, 8'hB2); gap(3);
    strobe(25, 8'hC3);
    model[25] = 8'hC3; model[28] = 8'hB2;
    awaitCycle(1'b1);
    checkAll("R4 partial page");

    // R4: off-page strobe ignored
    strobe(16, 8'h01); gap(2);
    strobe(40, 8'h02); gap(2);
    strobe(19, 8'h03);
    model[16] = 8'h01; model[19] = 8'h03;
    awaitCycle(1'b0);
    readByte(40, v); check("R4 off-page byte ignored", v, model[40]);
    readByte(16, v); check("R4 in-page byte kept", v, 8'h01);

    // R5: gap of exactly W joins the page
    strobe(48, 8'h4D); gap(W);
    strobe(50, 8'h5E);
    model[48] = 8'h4D; model[50] = 8'h5E;
    awaitCycle(1'b1);
    readByte(50, v); check("R5 gap W joins page", v, 8'h5E);

    // R5 R7: gap of W+1 lands during busy and is dropped
    strobe(56, 8'h6F); gap(W + 1);
    check("R5 cycle started after window", int'(rdyBusyN), 0);
    strobe(57, 8'h70);
    model[56] = 8'h6F;
    waitReady();
    gap(W + 3);
    check("R7 no second cycle", int'(rdyBusyN), 1);
    readByte(57, v); check("R7 busy strobe ignored", v, model[57]);
    readByte(56, v); check("R5 first byte written", v, 8'h6F);

    // R8: status while busy, bit 7 set in data
    strobe(3, 8'hA5);
    model[3] = 8'hA5;
    while (rdyBusyN) @(negedge clk);
    readByte(3, v); readByte(3, v2);
    check("R8 status first read", v, 8'h40);
    check("R8 status second read", v2, 8'h00);
    waitReady();
    readByte(3, v); check("R9 data after status", v, 8'hA5);

    // R8: bit 7 clear in data
    strobe(4, 8'h3C);
    model[4] = 8'h3C;
    while (rdyBusyN) @(negedge clk);
    readByte(4, v); readByte(4, v2);
    check("R8 polling bit inverted", v, 8'hC0);
    check("R8 toggle second read", v2, 8'h80);
    waitReady();
    checkAll("R9 final readback");

    $display("  == %0d vectors applied, %0d miscompares ==", nChk, nFail);
    $finish;
  end

endmodule